// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters into asynchronous serial frames on a single transmit line. A character is handed over on a valid/ready interface and parked in a one-entry holding register. From there the shifter takes it at the next bit-rate tick and sends a frame on the line: a start bit, 6, 7 or 8 data bits least significant first, an optional parity bit, and one or two stop bits. The parity bit can be even, odd, forced low or forced high. The bit-rate tick comes from an external divider, and each tick marks one bit boundary.

A mode word selects the frame shape. Its three fields are read once, when a frame is loaded, so software may change them while a frame is on the line. Control pulses enable or disable the transmitter, force a held break (line low) or end it, and reset the transmit path. Two status flags report whether a frame is on the line and whether the block has nothing left to send.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_active` is 0, `tx_empty` is 1 and `in_ready` is 0, because the transmitter starts disabled and with no break.
- R2: A frame starts only at the edge where `baud_tick` is high. The frame is a start bit of 0, the data bits least significant first, then the stop bits of 1. Each bit lasts from one tick edge to the next. An idle line is 1.
- R3: In the length field `mode_len`, code 2'b10 selects 7 data bits and code 2'b11 selects 6 data bits. Codes 2'b00 and 2'b01 both select 8 data bits.
- R4: In the parity field `mode_par`, any code with bit 2 set means no parity bit. 3'b000 gives even parity over the data bits, 3'b001 odd parity, 3'b010 a parity bit of 0, and 3'b011 a parity bit of 1.
- R5: Stop field `mode_stop` value 2'b10 gives two stop bits. Every other value gives one stop bit.
- R6: A `brk_start` pulse forces `txd` to 0 from the next cycle on, and no new frame starts while the break is held. A `brk_stop` pulse ends the break. When both pulses come in the same cycle, `brk_stop` wins.
- R7: `tx_enable` and `tx_disable` set and clear the enable state, and `tx_disable` wins when both are given. `in_ready` is high only while the block is enabled and the holding register is empty. A disabled block starts no new frame, but a frame already on the line is finished.
- R8: A `tx_reset` pulse returns the shifter to idle and discards the held character, so that from the next cycle `tx_active` is 0 and `tx_empty` is 1. The discarded character is never sent.
- R9: The mode fields are captured when a frame is loaded. Changing them during a frame does not alter that frame.
- R10: `tx_active` is 1 from the start bit until the last stop bit ends. `tx_empty` is 1 exactly when no character is held and no frame is on the line.
- R11: When a character is held at the tick that ends the last stop bit, its start bit follows at once, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| mode_len | input | 2 | Character length code |
| mode_par | input | 3 | Parity code |
| mode_stop | input | 2 | Stop-bit code |
| tx_enable | input | 1 | Enable pulse |
| tx_disable | input | 1 | Disable pulse, wins over enable |
| tx_reset | input | 1 | Transmit path reset pulse |
| brk_start | input | 1 | Begin held break |
| brk_stop | input | 1 | End held break, wins over start |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character value |
| in_ready | output | 1 | Holding register can accept |
| txd | output | 1 | Serial line |
| tx_active | output | 1 | Frame in progress |
| tx_empty | output | 1 | Nothing held and shifter idle |

## Verification
The hardest situation to reach is a character sitting in the holding register at the exact tick that ends the final stop bit. Only then does the back-to-back path run, and there the shifter has to load a new frame, with the mode then current, while it is leaving the stop state. The stimulus gets there by offering a second character while the first frame is still shifting, so the holding register is full well before the closing tick. The same arrangement is used under a mid-frame mode change and under a transmit reset, which has to throw away the waiting character. A behavioural model in the bench follows every cycle, so a one-cycle slip in loading or finishing shows up at once.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam int unsigned NB_W   = $clog2(CHAR_W + 1);
  localparam int unsigned CNT_W  = $clog2(CHAR_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            has_par;
    logic [1:0]      par_kind;
    logic            two_stop;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_mode(input logic [1:0] len_code,
                                             input logic [2:0] par_code,
                                             input logic [1:0] stop_code);
    frame_cfg_t c;
    unique case (len_code)
      2'b10:   c.nbits = NB_W'(CHAR_W - 1);
      2'b11:   c.nbits = NB_W'(CHAR_W - 2);
      default: c.nbits = NB_W'(CHAR_W);
    endcase
    c.has_par  = ~par_code[2];
    c.par_kind = par_code[1:0];
    c.two_stop = (stop_code == 2'b10);
    return c;
  endfunction

  function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                       input logic [NB_W-1:0]   nbits,
                                       input logic [1:0]        kind);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(nbits)) acc = acc ^ d[i];
    end
    unique case (kind)
      2'd0:    return acc;
      2'd1:    return ~acc;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic brk_set,
  input  logic brk_clr,
  output logic en_q,
  output logic brk_q
);

  logic en_d, brk_d;

  always_comb begin
    en_d = en_q;
    if (en_clr)      en_d = 1'b0;
    else if (en_set) en_d = 1'b1;

    brk_d = brk_q;
    if (brk_clr)      brk_d = 1'b0;
    else if (brk_set) brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      brk_q <= brk_d;
    end
  end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enabled,
  input  logic              flush,
  input  logic              take,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              hold_v,
  output logic [CHAR_W-1:0] hold_d
);

  logic accept;
  logic hold_v_d;

  assign in_ready = enabled & ~hold_v;
  assign accept   = in_valid & in_ready & ~flush;

  always_comb begin
    hold_v_d = hold_v;
    if (flush)       hold_v_d = 1'b0;
    else if (take)   hold_v_d = 1'b0;
    else if (accept) hold_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v <= 1'b0;
    else        hold_v <= hold_v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_d <= '0;
    else if (accept) hold_d <= in_data;
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_ok,
  input  logic              flush,
  input  logic [CHAR_W-1:0] load_data,
  input  frame_cfg_t        cfg,
  output logic              take,
  output logic              line,
  output logic              busy
);

  tx_state_e         state_q, state_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NB_W-1:0]   nb_q, nb_d;
  logic              haspar_q, haspar_d;
  logic              two_q, two_d;
  logic              parb_q, parb_d;
  logic              last_data, last_stop;

  assign last_data = (NB_W'(cnt_q) == nb_q - NB_W'(1));
  assign last_stop = (cnt_q == CNT_W'(two_q));

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    nb_d     = nb_q;
    haspar_d = haspar_q;
    two_d    = two_q;
    parb_d   = parb_q;
    take     = 1'b0;

    if (tick) begin
      unique case (state_q)
        ST_IDLE: take = start_ok;
        ST_START: begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (last_data) begin
            state_d = haspar_q ? ST_PAR : ST_STOP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_PAR: begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end
        ST_STOP: begin
          if (last_stop) begin
            if (start_ok) take = 1'b1;
            else          state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (flush) take = 1'b0;

    if (take) begin
      state_d  = ST_START;
      sh_d     = load_data;
      nb_d     = cfg.nbits;
      haspar_d = cfg.has_par;
      two_d    = cfg.two_stop;
      parb_d   = calc_parity(load_data, cfg.nbits, cfg.par_kind);
    end

    if (flush) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      nb_q     <= NB_W'(CHAR_W);
      haspar_q <= 1'b0;
      two_q    <= 1'b0;
      parb_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      nb_q     <= nb_d;
      haspar_q <= haspar_d;
      two_q    <= two_d;
      parb_q   <= parb_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_PAR:   line = parb_q;
      default:  line = 1'b1;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        mode_len,
  input  logic [2:0]        mode_par,
  input  logic [1:0]        mode_stop,
  input  logic              tx_enable,
  input  logic              tx_disable,
  input  logic              tx_reset,
  input  logic              brk_start,
  input  logic              brk_stop,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_active,
  output logic              tx_empty
);

  logic              rst_core_n;
  logic              en_q, brk_q;
  logic              hold_v, take, line, busy;
  logic [CHAR_W-1:0] hold_d;
  frame_cfg_t        cfg_now;

  uart_tx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  uart_tx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en_set  (tx_enable),
    .en_clr  (tx_disable),
    .brk_set (brk_start),
    .brk_clr (brk_stop),
    .en_q    (en_q),
    .brk_q   (brk_q)
  );

  uart_tx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enabled  (en_q),
    .flush    (tx_reset),
    .take     (take),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .hold_v   (hold_v),
    .hold_d   (hold_d)
  );

  assign cfg_now = decode_mode(mode_len, mode_par, mode_stop);

  uart_tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (baud_tick),
    .start_ok  (hold_v & en_q & ~brk_q),
    .flush     (tx_reset),
    .load_data (hold_d),
    .cfg       (cfg_now),
    .take      (take),
    .line      (line),
    .busy      (busy)
  );

  assign txd       = line & ~brk_q;
  assign tx_active = busy;
  assign tx_empty  = ~hold_v & ~busy;

endmodule

// File: rtl/uart_frame_tx_checker.sv
module uart_frame_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx_disable,
  input logic tx_reset,
  input logic brk_start,
  input logic brk_stop,
  input logic brk_on,
  input logic in_ready,
  input logic txd,
  input logic tx_active,
  input logic tx_empty
);

  assert_frame_starts_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(baud_tick));

  assert_line_holds_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !tx_reset && !brk_start && !brk_stop) |=> $stable(txd));

  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !brk_on) |-> txd);

  assert_break_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_start && !brk_stop) |=> !txd);

  assert_break_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_stop |=> !brk_on);

  assert_disable_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disable |=> !in_ready);

  assert_reset_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_active && tx_empty));

  assert_active_ends_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> ($past(baud_tick) || $past(tx_reset)));

endmodule

bind uart_frame_tx uart_frame_tx_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .baud_tick  (baud_tick),
  .tx_disable (tx_disable),
  .tx_reset   (tx_reset),
  .brk_start  (brk_start),
  .brk_stop   (brk_stop),
  .brk_on     (brk_q),
  .in_ready   (in_ready),
  .txd        (txd),
  .tx_active  (tx_active),
  .tx_empty   (tx_empty)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic [1:0] mode_len;
  logic [2:0] mode_par;
  logic [1:0] mode_stop;
  logic       tx_enable, tx_disable, tx_reset, brk_start, brk_stop;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready, txd, tx_active, tx_empty;

  int    checks = 0;
  int    bad    = 0;
  string cur_req = "R1";
  bit    cap_q[$];
  bit    exp_q[$];
  bit    tick_run = 0;

  uart_frame_tx dut (
    .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick),
    .mode_len (mode_len), .mode_par (mode_par), .mode_stop (mode_stop),
    .tx_enable (tx_enable), .tx_disable (tx_disable), .tx_reset (tx_reset),
    .brk_start (brk_start), .brk_stop (brk_stop),
    .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
    .txd (txd), .tx_active (tx_active), .tx_empty (tx_empty)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- requirement helpers ----------------
  function automatic int nbits_of(input logic [1:0] l);
    return (l == 2'b10) ? 7 : (l == 2'b11) ? 6 : 8;  // R3
  endfunction

  function automatic bit par_of(input logic [7:0] d, input int nb, input logic [2:0] p);
    bit acc = 0;
    for (int i = 0; i < nb; i++) acc ^= d[i];
    case (p[1:0])                                     // R4
      2'd0: return acc;
      2'd1: return ~acc;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic build_frame(input logic [7:0] d, input logic [1:0] l,
                             input logic [2:0] p, input logic [1:0] s);
    int nb = nbits_of(l);
    exp_q.push_back(1'b0);
    for (int i = 0; i < nb; i++) exp_q.push_back(d[i]);
    if (!p[2]) exp_q.push_back(par_of(d, nb, p));
    exp_q.push_back(1'b1);
    if (s == 2'b10) exp_q.push_back(1'b1);            // R5
  endtask

  function automatic string q2s(input bit q[$]);
    string r = "";
    foreach (q[i]) r = {r, q[i] ? "1" : "0"};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_ph, m_idx, m_scnt, m_nb;
  bit   m_two, m_haspar, m_parb, m_hv, m_en, m_brk;
  logic [7:0] m_char, m_hd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_scnt = 0; m_nb = 8; m_two = 0; m_haspar = 0;
      m_parb = 0; m_hv = 0; m_en = 0; m_brk = 0; m_char = 0; m_hd = 0;
    end else begin
      bit so, ld, acc_ok;
      so = m_hv && m_en && !m_brk && baud_tick;
      acc_ok = in_valid && m_en && !m_hv;
      ld = 0;
      if (tx_reset) begin
        m_ph = 0; m_hv = 0;
      end else begin
        if (baud_tick) begin
          case (m_ph)
            0: ld = so;
            1: begin m_ph = 2; m_idx = 0; end
            2: if (m_idx == m_nb - 1) begin m_ph = m_haspar ? 3 : 4; m_scnt = 0; end
               else m_idx++;
            3: begin m_ph = 4; m_scnt = 0; end
            default: if (m_scnt == (m_two ? 1 : 0)) begin
                       if (so) ld = 1; else m_ph = 0;
                     end else m_scnt++;
          endcase
        end
        if (ld) begin
          m_ph = 1; m_char = m_hd; m_nb = nbits_of(mode_len);
          m_haspar = !mode_par[2]; m_two = (mode_stop == 2'b10);
          m_parb = par_of(m_hd, m_nb, mode_par); m_hv = 0;
        end else if (acc_ok) begin
          m_hv = 1; m_hd = in_data;
        end
      end
      if (tx_disable) m_en = 0; else if (tx_enable) m_en = 1;
      if (brk_stop) m_brk = 0; else if (brk_start) m_brk = 1;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit e_txd;
      case (m_ph)
        0: e_txd = 1;
        1: e_txd = 0;
        2: e_txd = m_char[m_idx];
        3: e_txd = m_parb;
        default: e_txd = 1;
      endcase
      e_txd = e_txd && !m_brk;
      check({txd, tx_active, tx_empty, in_ready} ==
            {e_txd, m_ph != 0, !m_hv && m_ph == 0, m_en && !m_hv}, cur_req,
            $sformatf("%b", {txd, tx_active, tx_empty, in_ready}),
            $sformatf("%b", {e_txd, m_ph != 0, !m_hv && m_ph == 0, m_en && !m_hv}));
    end
  end

  // ---------------- drivers ----------------
  initial begin
    int cnt = 0;
    baud_tick = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % TICK_DIV;
      baud_tick = tick_run && (cnt == 0);
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic put_char(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic capture_frames;
    cap_q.delete();
    @(negedge clk); #1;
    while (!tx_active) begin @(negedge clk); #1; end
    while (tx_active) begin
      if (baud_tick) cap_q.push_back(txd);
      @(negedge clk); #1;
    end
  endtask

  task automatic set_mode(input logic [1:0] l, input logic [2:0] p, input logic [1:0] s);
    @(negedge clk);
    mode_len = l; mode_par = p; mode_stop = s;
  endtask

  task automatic one_frame(input logic [7:0] d, input logic [1:0] l,
                           input logic [2:0] p, input logic [1:0] s, input string req);
    cur_req = req;
    set_mode(l, p, s);
    exp_q.delete();
    build_frame(d, l, p, s);
    fork
      capture_frames();
      put_char(d);
    join
    check(cap_q == exp_q, req, q2s(cap_q), q2s(exp_q));
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 0; mode_len = 0; mode_par = 3'b100; mode_stop = 0;
    tx_enable = 0; tx_disable = 0; tx_reset = 0; brk_start = 0; brk_stop = 0;
    in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    check({txd, tx_active, tx_empty, in_ready} == 4'b1010, "R1",
          $sformatf("%b", {txd, tx_active, tx_empty, in_ready}), "1010");
    tick_run = 1;

    cur_req = "R7";
    pulse(tx_enable);
    #1 check(in_ready == 1, "R7", $sformatf("%b", in_ready), "1");

    one_frame(8'hA5, 2'b00, 3'b100, 2'b00, "R2");
    one_frame(8'h35, 2'b10, 3'b000, 2'b00, "R3");
    one_frame(8'h2C, 2'b11, 3'b001, 2'b00, "R3");
    one_frame(8'h96, 2'b01, 3'b011, 2'b10, "R5");
    one_frame(8'hFF, 2'b00, 3'b010, 2'b01, "R4");
    one_frame(8'h07, 2'b10, 3'b001, 2'b11, "R4");
    one_frame(8'h3C, 2'b00, 3'b110, 2'b10, "R4");

    // R9: mode changed while the frame is on the line
    cur_req = "R9";
    set_mode(2'b00, 3'b000, 2'b10);
    exp_q.delete(); build_frame(8'hC3, 2'b00, 3'b000, 2'b10);
    fork
      capture_frames();
      begin
        put_char(8'hC3);
        @(negedge clk); while (!tx_active) @(negedge clk);
        mode_len = 2'b11; mode_par = 3'b100; mode_stop = 2'b00;
      end
    join
    check(cap_q == exp_q, "R9", q2s(cap_q), q2s(exp_q));

    // R11: two characters back to back, no idle bit between
    cur_req = "R11";
    set_mode(2'b10, 3'b001, 2'b00);
    exp_q.delete();
    build_frame(8'h55, 2'b10, 3'b001, 2'b00);
    build_frame(8'h0F, 2'b10, 3'b001, 2'b00);
    fork
      capture_frames();
      begin put_char(8'h55); put_char(8'h0F); end
    join
    check(cap_q == exp_q, "R11", q2s(cap_q), q2s(exp_q));
    #1 check(tx_empty == 1, "R10", $sformatf("%b", tx_empty), "1");

    // R6: break holds the line low and blocks a pending frame
    cur_req = "R6";
    set_mode(2'b00, 3'b100, 2'b00);
    pulse(brk_start);
    put_char(8'h81);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (i % 10 == 0)
        check(txd == 0 && tx_active == 0, "R6",
              $sformatf("%b%b", txd, tx_active), "00");
    end
    exp_q.delete(); build_frame(8'h81, 2'b00, 3'b100, 2'b00);
    fork
      capture_frames();
      begin @(negedge clk); brk_start = 1; brk_stop = 1;
            @(negedge clk); brk_start = 0; brk_stop = 0; end
    join
    check(cap_q == exp_q, "R6", q2s(cap_q), q2s(exp_q));

    // R7: disable mid-frame finishes the frame; disable wins over enable
    cur_req = "R7";
    exp_q.delete(); build_frame(8'h6E, 2'b00, 3'b100, 2'b00);
    fork
      capture_frames();
      begin
        put_char(8'h6E);
        @(negedge clk); while (!tx_active) @(negedge clk);
        tx_enable = 1; tx_disable = 1;
        @(negedge clk); tx_enable = 0; tx_disable = 0;
      end
    join
    check(cap_q == exp_q, "R7", q2s(cap_q), q2s(exp_q));
    #1 check(in_ready == 0, "R7", $sformatf("%b", in_ready), "0");
    @(negedge clk); in_valid = 1; in_data = 8'h11;
    repeat (30) @(negedge clk);
    in_valid = 0; #1;
    check(tx_active == 0 && tx_empty == 1, "R7",
          $sformatf("%b%b", tx_active, tx_empty), "01");
    pulse(tx_enable);

    // R8: transmit reset discards both the frame and the held character
    cur_req = "R8";
    put_char(8'hAA);
    @(negedge clk); while (!tx_active) @(negedge clk);
    put_char(8'hBB);
    #1 check(tx_empty == 0, "R10", $sformatf("%b", tx_empty), "0");
    pulse(tx_reset);
    #1 check(tx_active == 0 && tx_empty == 1 && txd == 1, "R8",
             $sformatf("%b%b%b", tx_active, tx_empty, txd), "011");
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (tx_active) begin
        check(0, "R8", "active", "idle");
        break;
      end
    end
    check(tx_active == 0, "R8", $sformatf("%b", tx_active), "0");
    one_frame(8'h42, 2'b00, 3'b000, 2'b00, "R10");

    repeat (8) @(negedge clk);
    finish_run();
  end

endmodule